// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block turns a start/stop framed serial line into parallel characters for a host. A six-bit mode word, held steady while characters arrive, selects the character length (5 to 8 bits), optional odd or even parity and the number of clock ticks per bit (1, 16 or 64). Every rising edge of `clk` is one sample tick. The receive line passes through a reset-to-idle synchronizer. With the x16 and x64 rates, a low level is accepted as a start bit only if it is still low half a bit later. Each later bit is taken at its midpoint, least significant data bit first.

Reception is double buffered. The shift engine frames the next character while the host still holds the previous one in the read buffer. A finished character is copied into the buffer and raises `data_ready`. The host takes it by pulsing `rd_pulse`. Parity, framing and overrun problems each set a separate sticky flag. The flags stay set until `err_clr` is pulsed.

Top module: `async_rx_core`

## Requirements
- R1: `mode_cfg[3:2]` selects the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits arrive LSB first. Buffer bits above the character length read as zero.
- R2: When `mode_cfg[4]` is 1, a parity bit follows the data. `mode_cfg[5]`=1 expects even parity over data plus parity bit, and 0 expects odd parity. A mismatch sets `parity_err`. When `mode_cfg[4]` is 0, no parity bit is expected and `parity_err` is never set.
- R3: `mode_cfg[1:0]` selects the ticks per bit: 10 gives 16, 11 gives 64, and 01 or 00 gives 1 tick per bit.
- R4: At 16 or 64 ticks per bit, a low pulse that has ended by the half-bit re-sample is discarded. No character is produced and `data_ready` stays 0.
- R5: If the first stop bit is sampled low, `framing_err` is set. The receiver then waits for the line to return high before it looks for a new start bit.
- R6: `data_ready` rises on the cycle after the stop bit is sampled and the character is copied to `rx_data`. A `rd_pulse` with no copy in the same cycle clears `data_ready` on the next edge.
- R7: If a character is copied while `data_ready` is 1 and no read occurs in that cycle, `overrun_err` is set and `rx_data` takes the new character.
- R8: A `rd_pulse` in the same cycle as a copy consumes the old character. `data_ready` stays 1, `rx_data` shows the new character and `overrun_err` is not set.
- R9: `err_clr` clears all three error flags on the next edge. A flag that is being set in the same cycle stays set.
- R10: While the next character is being shifted in, `rx_data` and `data_ready` keep the previous unread character unchanged.
- R11: After a synchronous active-low reset, `data_ready`, the three error flags and `rx_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one sample tick |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_cfg | input | 6 | Rate [1:0], length [3:2], parity enable [4], even select [5] |
| rx_in | input | 1 | Serial receive line, idle high |
| rd_pulse | input | 1 | Host takes the buffered character |
| err_clr | input | 1 | Clear all sticky error flags |
| rx_data | output | 8 | Buffered character, upper unused bits zero |
| data_ready | output | 1 | A character is waiting in the buffer |
| parity_err | output | 1 | Sticky parity error |
| overrun_err | output | 1 | Sticky overrun error |
| framing_err | output | 1 | Sticky framing error |

## Verification
Two pairs of events can fall on the same clock edge. A host read can coincide with a new character being copied into the buffer, and an error clear can coincide with a copy that sets an error. The bench first times one full frame to learn on which edge `data_ready` rises. It then places `rd_pulse` or `err_clr` on exactly that edge for a second frame. It judges the result by `data_ready` staying 1 with no overrun and the new data visible, or by the parity flag surviving the clear.

// File: rtl/async_rx_pkg.sv
// Package: shared constants, state type and mode-field decoders for the
// asynchronous receiver. Assumes the mode layout described in the brief.
package async_rx_pkg;

    localparam int CHAR_W    = 8;
    localparam int RATE_MID  = 16;
    localparam int RATE_HIGH = 64;
    localparam int TICK_W    = $clog2(RATE_HIGH);
    localparam int IDX_W     = $clog2(CHAR_W);
    localparam int LEN_W     = IDX_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_t;

    // Ticks per bit minus one for a rate code.
    function automatic logic [TICK_W-1:0] bit_reload(input logic [1:0] code);
        case (code)
            2'b10:   return TICK_W'(RATE_MID - 1);
            2'b11:   return TICK_W'(RATE_HIGH - 1);
            default: return '0;
        endcase
    endfunction

    // Half a bit in ticks minus one for a rate code.
    function automatic logic [TICK_W-1:0] half_reload(input logic [1:0] code);
        case (code)
            2'b10:   return TICK_W'(RATE_MID / 2 - 1);
            2'b11:   return TICK_W'(RATE_HIGH / 2 - 1);
            default: return '0;
        endcase
    endfunction

    // Number of data bits for a length code (5 to 8).
    function automatic logic [LEN_W-1:0] char_bits(input logic [1:0] code);
        return LEN_W'(5) + LEN_W'(code);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
// Module: rx_line_sync
// Brings the asynchronous receive line into the clock domain through a
// chain of STAGES flops. Assumes an idle-high line, so it resets to 1.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage captures the raw line.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= line_i;
                end
            end else begin : g_next
                // Later stages pass the value along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign line_o = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_engine.sv
// Module: rx_frame_engine
// Finds start bits, times the mid-bit samples, shifts in 5..8 data bits
// LSB first, checks parity and the first stop bit, and gives a one-cycle
// done pulse with the aligned character and its error bits. The mode
// fields are latched at start detection. Assumes rx_s is already synchronous.
module rx_frame_engine
    import async_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_s,
    input  logic [5:0]        mode_i,
    output logic              done_o,
    output logic [CHAR_W-1:0] data_o,
    output logic              perr_o,
    output logic              ferr_o
);
    rx_state_t         state;
    logic [TICK_W-1:0] cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [CHAR_W-1:0] shreg;
    logic              par_acc;
    logic              par_bad;
    logic [1:0]        rate_q;
    logic [1:0]        len_q;
    logic              pen_q;
    logic              even_q;

    // Frame sequencer: start check, bit timing, shifting and error capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            par_bad <= 1'b0;
            rate_q  <= '0;
            len_q   <= '0;
            pen_q   <= 1'b0;
            even_q  <= 1'b0;
            done_o  <= 1'b0;
            data_o  <= '0;
            perr_o  <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (!rx_s) begin
                        rate_q  <= mode_i[1:0];
                        len_q   <= mode_i[3:2];
                        pen_q   <= mode_i[4];
                        even_q  <= mode_i[5];
                        bit_idx <= '0;
                        shreg   <= '0;
                        par_acc <= 1'b0;
                        par_bad <= 1'b0;
                        if (mode_i[1]) begin
                            state <= ST_START;
                            cnt   <= half_reload(mode_i[1:0]);
                        end else begin
                            state <= ST_DATA;
                            cnt   <= '0;
                        end
                    end
                end
                ST_START: begin
                    if (cnt == '0) begin
                        if (rx_s) begin
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_DATA;
                            cnt   <= bit_reload(rate_q);
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt == '0) begin
                        shreg   <= {rx_s, shreg[CHAR_W-1:1]};
                        par_acc <= par_acc ^ rx_s;
                        bit_idx <= bit_idx + 1'b1;
                        cnt     <= bit_reload(rate_q);
                        if ({1'b0, bit_idx} == char_bits(len_q) - 1'b1)
                            state <= pen_q ? ST_PAR : ST_STOP;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_PAR: begin
                    if (cnt == '0) begin
                        par_bad <= (par_acc ^ rx_s) ^ ~even_q;
                        cnt     <= bit_reload(rate_q);
                        state   <= ST_STOP;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_STOP: begin
                    if (cnt == '0) begin
                        done_o <= 1'b1;
                        data_o <= shreg >> (LEN_W'(CHAR_W) - char_bits(len_q));
                        perr_o <= pen_q & par_bad;
                        ferr_o <= ~rx_s;
                        state  <= ST_HOLD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (rx_s) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: a finished character never carries bits above its length.
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((data_o >> char_bits(len_q)) == '0));

    // R4: a start that has gone high at the half-bit check is dropped.
    a_r4_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && cnt == '0 && rx_s) |=> (state == ST_IDLE && !done_o));

    // R5: a low stop sample yields a framing-flagged character.
    a_r5_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && cnt == '0 && !rx_s) |=> (done_o && ferr_o));

    // R2: with parity off, a parity error is never reported.
    a_r2_no_parity_off: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !pen_q) |-> !perr_o);
endmodule

// File: rtl/rx_hold_buffer.sv
// Module: rx_hold_buffer
// Read-side holding register with the ready flag and three sticky error
// flags. A copy beats a read in the same cycle, and a set beats a clear.
// Assumes load_i is a single-cycle pulse.
module rx_hold_buffer
    import async_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CHAR_W-1:0] data_i,
    input  logic              perr_i,
    input  logic              ferr_i,
    input  logic              rd_i,
    input  logic              clr_i,
    output logic [CHAR_W-1:0] data_o,
    output logic              ready_o,
    output logic              perr_o,
    output logic              oerr_o,
    output logic              ferr_o
);
    localparam int NFLAG = 3;

    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_q;

    // Collect the set conditions for parity, overrun and framing.
    always_comb begin
        flag_set[0] = load_i & perr_i;
        flag_set[1] = load_i & ready_o & ~rd_i;
        flag_set[2] = load_i & ferr_i;
    end

    // Buffer register and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            ready_o <= 1'b0;
        end else if (load_i) begin
            data_o  <= data_i;
            ready_o <= 1'b1;
        end else if (rd_i) begin
            ready_o <= 1'b0;
        end
    end

    generate
        for (genvar f = 0; f < NFLAG; f++) begin : g_flag
            // Sticky flag: set wins over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)           flag_q[f] <= 1'b0;
                else if (flag_set[f]) flag_q[f] <= 1'b1;
                else if (clr_i)       flag_q[f] <= 1'b0;
            end
        end
    endgenerate

    assign perr_o = flag_q[0];
    assign oerr_o = flag_q[1];
    assign ferr_o = flag_q[2];

    // R6: a copy always leaves the buffer ready.
    a_r6_ready_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ready_o);

    // R6: a lone read empties the buffer.
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !load_i) |=> !ready_o);

    // R7: an unread buffer hit by a copy reports overrun.
    a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && ready_o && !rd_i) |=> oerr_o);

    // R8: a read coinciding with a copy does not raise overrun.
    a_r8_read_and_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && rd_i && !oerr_o && !clr_i) |=> (ready_o && !oerr_o));

    // R9: a clear with no copy empties every flag.
    a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !load_i) |=> (!perr_o && !oerr_o && !ferr_o));

    // R10: with no copy, the held character does not change.
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(data_o));
endmodule

// File: rtl/async_rx_core.sv
// Module: async_rx_core
// Top of the asynchronous receiver: line synchronizer, frame engine and
// double-buffered read register with sticky flags. Assumes mode_cfg is
// stable while a character is arriving, and one sample tick per clock.
module async_rx_core
    import async_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        mode_cfg,
    input  logic              rx_in,
    input  logic              rd_pulse,
    input  logic              err_clr,
    output logic [CHAR_W-1:0] rx_data,
    output logic              data_ready,
    output logic              parity_err,
    output logic              overrun_err,
    output logic              framing_err
);
    logic              rx_s;
    logic              done;
    logic [CHAR_W-1:0] frame_data;
    logic              frame_perr;
    logic              frame_ferr;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rx_in),
        .line_o (rx_s)
    );

    rx_frame_engine u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_s   (rx_s),
        .mode_i (mode_cfg),
        .done_o (done),
        .data_o (frame_data),
        .perr_o (frame_perr),
        .ferr_o (frame_ferr)
    );

    rx_hold_buffer u_buffer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (done),
        .data_i  (frame_data),
        .perr_i  (frame_perr),
        .ferr_i  (frame_ferr),
        .rd_i    (rd_pulse),
        .clr_i   (err_clr),
        .data_o  (rx_data),
        .ready_o (data_ready),
        .perr_o  (parity_err),
        .oerr_o  (overrun_err),
        .ferr_o  (framing_err)
    );
endmodule

// File: tb/async_rx_core_bench.sv
module async_rx_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] mode_cfg = 6'b001110;
    logic       rx_in = 1'b1;
    logic       rd_pulse = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       data_ready;
    logic       parity_err;
    logic       overrun_err;
    logic       framing_err;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    async_rx_core u_async_rx_core (
        .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .rx_in(rx_in),
        .rd_pulse(rd_pulse), .err_clr(err_clr), .rx_data(rx_data),
        .data_ready(data_ready), .parity_err(parity_err),
        .overrun_err(overrun_err), .framing_err(framing_err)
    );

    // Vector: mode[27:22] data[21:14] flip_par[13] bad_stop[12]
    //         exp_data[11:4] exp_perr[3] exp_ferr[2] spare[1:0]
    localparam int NVEC = 11;
    localparam logic [27:0] VEC [NVEC] = '{
        {6'b001110, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 2'b00}, // R1 8b x16
        {6'b000010, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0, 2'b00}, // R1 5b
        {6'b000110, 8'hC3, 1'b0, 1'b0, 8'h03, 1'b0, 1'b0, 2'b00}, // R1 6b
        {6'b001010, 8'hD5, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 2'b00}, // R1 7b
        {6'b111110, 8'h37, 1'b0, 1'b0, 8'h37, 1'b0, 1'b0, 2'b00}, // R2 even ok
        {6'b011110, 8'h37, 1'b1, 1'b0, 8'h37, 1'b1, 1'b0, 2'b00}, // R2 odd bad
        {6'b010010, 8'h0A, 1'b0, 1'b0, 8'h0A, 1'b0, 1'b0, 2'b00}, // R2 odd 5b ok
        {6'b001101, 8'h5C, 1'b0, 1'b0, 8'h5C, 1'b0, 1'b0, 2'b00}, // R3 x1
        {6'b001111, 8'h96, 1'b0, 1'b0, 8'h96, 1'b0, 1'b0, 2'b00}, // R3 x64
        {6'b110110, 8'h2B, 1'b1, 1'b1, 8'h2B, 1'b1, 1'b1, 2'b00}, // R5 even 6b
        {6'b001100, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 2'b00}  // R3 code 00
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int ticks_of(input logic [1:0] code);
        return (code == 2'b10) ? 16 : (code == 2'b11) ? 64 : 1;
    endfunction

    // Drive one frame starting at the current negedge; returns after idle time.
    task automatic send_char(input logic [5:0] m, input logic [7:0] d,
                             input logic flip, input logic bad_stop);
        int f;
        int n;
        logic pb;
        f = ticks_of(m[1:0]);
        n = 5 + int'(m[3:2]);
        pb = 1'b0;
        for (int i = 0; i < n; i++) pb = pb ^ d[i];
        if (!m[5]) pb = ~pb;
        rx_in = 1'b0;
        repeat (f) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rx_in = d[i];
            repeat (f) @(negedge clk);
        end
        if (m[4]) begin
            rx_in = pb ^ flip;
            repeat (f) @(negedge clk);
        end
        rx_in = ~bad_stop;
        repeat (f) @(negedge clk);
        rx_in = 1'b1;
        repeat (2 * f + 4) @(negedge clk);
    endtask

    task automatic read_and_clear();
        rd_pulse = 1'b1;
        err_clr  = 1'b1;
        @(negedge clk);
        rd_pulse = 1'b0;
        err_clr  = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int lat;
        logic [27:0] v;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 ready", 32'(data_ready), 0);
        chk("R11 data", 32'(rx_data), 0);
        chk("R11 perr", 32'(parity_err), 0);
        chk("R11 oerr", 32'(overrun_err), 0);
        chk("R11 ferr", 32'(framing_err), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Table walk: R1 R2 R3 R5 R6
        for (int k = 0; k < NVEC; k++) begin
            v = VEC[k];
            mode_cfg = v[27:22];
            send_char(v[27:22], v[21:14], v[13], v[12]);
            chk($sformatf("R6 vec%0d ready", k), 32'(data_ready), 1);
            chk($sformatf("R1 vec%0d data", k), 32'(rx_data), 32'(v[11:4]));
            chk($sformatf("R2 vec%0d perr", k), 32'(parity_err), 32'(v[3]));
            chk($sformatf("R5 vec%0d ferr", k), 32'(framing_err), 32'(v[2]));
            read_and_clear();
            chk($sformatf("R6 vec%0d read clears", k), 32'(data_ready), 0);
            chk($sformatf("R9 vec%0d flags cleared", k),
                32'({parity_err, overrun_err, framing_err}), 0);
        end

        // R4: short low pulse at x16 is not a start bit
        mode_cfg = 6'b001110;
        rx_in = 1'b0;
        repeat (4) @(negedge clk);
        rx_in = 1'b1;
        repeat (200) @(negedge clk);
        chk("R4 glitch ignored ready", 32'(data_ready), 0);
        chk("R4 glitch ignored flags",
            32'({parity_err, overrun_err, framing_err}), 0);

        // Calibrate copy latency with char A (no read)
        lat = 0;
        fork
            send_char(6'b001110, 8'h11, 1'b0, 1'b0);
            begin
                while (!data_ready) begin @(negedge clk); lat++; end
            end
        join
        chk("R6 char A data", 32'(rx_data), 32'h11);

        // R10: while B arrives, A is held; then R7 overrun
        fork
            send_char(6'b001110, 8'h22, 1'b0, 1'b0);
            begin
                repeat (60) @(negedge clk);
                chk("R10 held data", 32'(rx_data), 32'h11);
                chk("R10 held ready", 32'(data_ready), 1);
                chk("R10 no early overrun", 32'(overrun_err), 0);
            end
        join
        chk("R7 overrun set", 32'(overrun_err), 1);
        chk("R7 data replaced", 32'(rx_data), 32'h22);
        read_and_clear();

        // R8: read lands on the copy edge
        send_char(6'b001110, 8'h33, 1'b0, 1'b0);
        fork
            send_char(6'b001110, 8'h44, 1'b0, 1'b0);
            begin
                repeat (lat - 1) @(negedge clk);
                rd_pulse = 1'b1;
                @(negedge clk);
                rd_pulse = 1'b0;
            end
        join
        chk("R8 ready kept", 32'(data_ready), 1);
        chk("R8 new data", 32'(rx_data), 32'h44);
        chk("R8 no overrun", 32'(overrun_err), 0);
        read_and_clear();

        // R9: clear lands on a copy that sets parity error
        mode_cfg = 6'b111110;
        lat = 0;
        fork
            send_char(6'b111110, 8'h5A, 1'b1, 1'b0);
            begin
                while (!data_ready) begin @(negedge clk); lat++; end
            end
        join
        chk("R2 even bad parity", 32'(parity_err), 1);
        read_and_clear();
        chk("R9 clear empties", 32'(parity_err), 0);
        fork
            send_char(6'b111110, 8'h5A, 1'b1, 1'b0);
            begin
                repeat (lat - 1) @(negedge clk);
                err_clr = 1'b1;
                @(negedge clk);
                err_clr = 1'b0;
            end
        join
        chk("R9 set beats clear", 32'(parity_err), 1);
        chk("R9 data", 32'(rx_data), 32'h5A);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule